// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a pointer and writes it into the pointer's tag field. A 16-bit linear feedback shift register seed, held in a caller-supplied state word, is clocked four times. The four feedback bits form a step count. Starting from the start tag kept in the same state word, the block then walks upward through the sixteen tag values, wrapping modulo 16. It skips every value whose bit is set in the effective exclusion mask, and stops once the step count is used up.

The caller presents the pointer, a per-request exclusion mask, a control word and the current state word, then pulses `start`. When `done` pulses, the tagged pointer is available. The rewritten state word is also available, holding the chosen tag and the advanced seed, and the caller feeds it back as the state of the next request. The walk is iterative and tests one candidate tag per cycle, so latency depends on the mask and on the step count.

Top module: `rnd_tag_gen`

## Requirements
- R1: The effective exclusion mask is `req_mask | ctrl_word[15:0]`. Bit k set means tag value k may not be chosen.
- R2: The seed is `state_in[23:8]` and is clocked four times. Each clock computes b = s[5]^s[3]^s[2]^s[0] and then s = {b, s[15:1]}. The b of clock i (i = 0..3) is bit i of the step count. `state_out[23:8]` holds the seed after the fourth clock, and `state_out[7:4]` is 0.
- R3: When all 16 bits of the effective mask are set, the chosen tag is 0. The seed still advances.
- R4: With a step count of 0, the chosen tag is the first value at or after the start tag `state_in[3:0]`, counting upward modulo 16, that is not excluded.
- R5: With a nonzero step count n, the tag moves from the start tag to the next non-excluded value (upward, modulo 16) n times. The last value reached is the chosen tag.
- R6: `ctrl_word[16]` is the random-mode bit. When it is 1 and the seed is 0, the seed 0x0001 is used in its place before clocking. When it is 0, a zero seed is clocked as it is.
- R7: `ptr_out` equals the captured `ptr_in` with bits [59:56] replaced by the chosen tag. All other bits are unchanged.
- R8: `state_out[3:0]` holds the chosen tag, so feeding `state_out` back as `state_in` continues the sequence.
- R9: `start` is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the result is ready. `done` is then a one-cycle pulse. A `start` while `busy` is high is ignored. `ptr_out` and `state_out` change only in a `done` cycle and hold until the next one.
- R10: After reset, `busy`, `done`, `ptr_out` and `state_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted while busy is low |
| ptr_in | input | 64 | Pointer to be tagged |
| req_mask | input | 16 | Per-request exclusion mask |
| ctrl_word | input | 17 | [15:0] exclusion mask, [16] random-mode bit |
| state_in | input | 24 | [3:0] start tag, [23:8] seed |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ptr_out | output | 64 | Tagged pointer |
| state_out | output | 24 | Updated state: [3:0] chosen tag, [23:8] advanced seed |

## Verification
A wrong seed register or a wrong tap shows up in the same `done` pulse as a wrong `state_out[23:8]` and usually as a wrong step count. When state words are chained, the error persists in every later result. A walker that miscounts steps, or that tests the wrong candidate, puts a wrong tag on `ptr_out` and `state_out[3:0]` in that same pulse. It may also land on an excluded value, which the mask-membership property catches at once. A stuck walker never raises `done`, and the per-request timeout exposes it within a few hundred cycles.

// File: rtl/tagg_pkg.sv
package tagg_pkg;
  localparam int TAG_W    = 4;
  localparam int NTAG     = 1 << TAG_W;
  localparam int SEED_W   = 16;
  localparam int STEPS    = TAG_W;
  localparam int SEED_LSB = 8;
  localparam int STATE_W  = SEED_LSB + SEED_W;
  localparam int RND_BIT  = NTAG;
  localparam int CTRL_W   = NTAG + 1;

  // Feedback bit of one shift-register clock.
  function automatic logic seed_fb(input logic [SEED_W-1:0] s);
    return s[5] ^ s[3] ^ s[2] ^ s[0];
  endfunction

  // One clock of the shift register: feedback enters at the top.
  function automatic logic [SEED_W-1:0] seed_clock(input logic [SEED_W-1:0] s);
    return {seed_fb(s), s[SEED_W-1:1]};
  endfunction

  // Whether a candidate tag is blocked by the mask.
  function automatic logic tag_blocked(input logic [NTAG-1:0] m,
                                       input logic [TAG_W-1:0] t);
    return m[t];
  endfunction
endpackage

// File: rtl/tagg_seed_adv.sv
module tagg_seed_adv
  import tagg_pkg::*;
(
  input  logic [SEED_W-1:0] seed_in,
  input  logic              rnd_mode,
  output logic [SEED_W-1:0] seed_out,
  output logic [STEPS-1:0]  step_cnt
);
  localparam logic [SEED_W-1:0] SEED_ONE = {{(SEED_W-1){1'b0}}, 1'b1};

  logic [SEED_W-1:0] chain [0:STEPS];

  // A zero seed would lock the register; random mode forces a live value.
  assign chain[0] = (rnd_mode && (seed_in == '0)) ? SEED_ONE : seed_in;

  for (genvar i = 0; i < STEPS; i++) begin : g_clk
    assign step_cnt[i]  = seed_fb(chain[i]);
    assign chain[i + 1] = seed_clock(chain[i]);
  end

  assign seed_out = chain[STEPS];
endmodule

// File: rtl/tagg_walker.sv
module tagg_walker
  import tagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [TAG_W-1:0] steps,
  input  logic [NTAG-1:0]  mask,
  output logic             fin,
  output logic [TAG_W-1:0] tag_out,
  output logic             active,
  output logic             cand_hit
);
  localparam logic [TAG_W-1:0] ONE = {{(TAG_W-1){1'b0}}, 1'b1};

  typedef enum logic {W_IDLE, W_RUN} wstate_t;

  wstate_t          st;
  logic [TAG_W-1:0] cur;
  logic [TAG_W-1:0] remain;
  logic [NTAG-1:0]  mask_r;
  logic [TAG_W-1:0] cand;
  logic             all_blocked;

  // Candidate is the value after cur, wrapping naturally at the tag width.
  assign cand        = cur + ONE;
  assign cand_hit    = !tag_blocked(mask_r, cand);
  assign all_blocked = &mask;
  assign active      = (st == W_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      cur     <= '0;
      remain  <= '0;
      mask_r  <= '0;
      fin     <= 1'b0;
      tag_out <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        W_IDLE: begin
          if (load) begin
            if (all_blocked) begin
              fin     <= 1'b1;
              tag_out <= '0;
            end else begin
              // A zero step count is one step from the value just below start.
              cur    <= (steps == '0) ? (start_tag - ONE) : start_tag;
              remain <= (steps == '0) ? ONE : steps;
              mask_r <= mask;
              st     <= W_RUN;
            end
          end
        end
        W_RUN: begin
          cur <= cand;
          if (cand_hit) begin
            if (remain == ONE) begin
              fin     <= 1'b1;
              tag_out <= cand;
              st      <= W_IDLE;
            end else begin
              remain <= remain - ONE;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagg_ptr_ins.sv
module tagg_ptr_ins
  import tagg_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
)(
  input  logic [PTR_W-1:0] ptr_in,
  input  logic [TAG_W-1:0] tag,
  output logic [PTR_W-1:0] ptr_out
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  logic unused_old_tag;
  assign unused_old_tag = ^ptr_in[TAG_MSB:TAG_LSB];

  for (genvar b = 0; b < PTR_W; b++) begin : g_bit
    if (b >= TAG_LSB && b <= TAG_MSB) begin : g_tag
      assign ptr_out[b] = tag[b - TAG_LSB];
    end else begin : g_pass
      assign ptr_out[b] = ptr_in[b];
    end
  end
endmodule

// File: rtl/rnd_tag_gen.sv
module rnd_tag_gen
  import tagg_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PTR_W-1:0]   ptr_in,
  input  logic [NTAG-1:0]    req_mask,
  input  logic [CTRL_W-1:0]  ctrl_word,
  input  logic [STATE_W-1:0] state_in,
  output logic               busy,
  output logic               done,
  output logic [PTR_W-1:0]   ptr_out,
  output logic [STATE_W-1:0] state_out
);
  logic               busy_q;
  logic               done_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [SEED_W-1:0]  seed_q;
  logic [NTAG-1:0]    mask_q;
  logic [PTR_W-1:0]   ptr_out_q;
  logic [STATE_W-1:0] state_out_q;

  logic               accept;
  logic [NTAG-1:0]    eff_mask;
  logic [SEED_W-1:0]  seed_next;
  logic [STEPS-1:0]   step_cnt;
  logic               w_fin;
  logic [TAG_W-1:0]   w_tag;
  logic               w_active;
  logic               w_hit;
  logic [PTR_W-1:0]   tagged_ptr;
  logic               unused_sig;

  assign unused_sig = ^state_in[SEED_LSB-1:TAG_W] ^ w_active ^ w_hit;

  assign accept   = start && !busy_q;
  assign eff_mask = req_mask | ctrl_word[NTAG-1:0];

  tagg_seed_adv u_seed (
    .seed_in  (state_in[SEED_LSB +: SEED_W]),
    .rnd_mode (ctrl_word[RND_BIT]),
    .seed_out (seed_next),
    .step_cnt (step_cnt)
  );

  tagg_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .start_tag (state_in[TAG_W-1:0]),
    .steps     (step_cnt),
    .mask      (eff_mask),
    .fin       (w_fin),
    .tag_out   (w_tag),
    .active    (w_active),
    .cand_hit  (w_hit)
  );

  tagg_ptr_ins #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) u_ins (
    .ptr_in  (ptr_q),
    .tag     (w_tag),
    .ptr_out (tagged_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      ptr_q       <= '0;
      seed_q      <= '0;
      mask_q      <= '0;
      ptr_out_q   <= '0;
      state_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        ptr_q  <= ptr_in;
        seed_q <= seed_next;
        mask_q <= eff_mask;
      end
      if (w_fin) begin
        busy_q      <= 1'b0;
        done_q      <= 1'b1;
        ptr_out_q   <= tagged_ptr;
        state_out_q <= {seed_q, {(SEED_LSB-TAG_W){1'b0}}, w_tag};
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign ptr_out   = ptr_out_q;
  assign state_out = state_out_q;
endmodule

// File: rtl/rnd_tag_gen_chk.sv
module rnd_tag_gen_chk
  import tagg_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
)(
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [PTR_W-1:0]   ptr_out,
  input logic [STATE_W-1:0] state_out,
  input logic [NTAG-1:0]    mask_q
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_out) |-> done);

  assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_out) |-> done);

  assert_tag_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ptr_out[TAG_LSB +: TAG_W] == state_out[TAG_W-1:0]) &&
             (state_out[SEED_LSB-1:TAG_W] == '0));

  assert_full_mask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&mask_q)) |-> (state_out[TAG_W-1:0] == '0));

  assert_tag_allowed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(&mask_q)) |-> !mask_q[state_out[TAG_W-1:0]]);
endmodule

bind rnd_tag_gen rnd_tag_gen_chk #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .ptr_out   (ptr_out),
  .state_out (state_out),
  .mask_q    (mask_q)
);

// File: tb/sim_rnd_tag_gen.sv
`timescale 1ns/1ps
module sim_rnd_tag_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ptr_in = '0;
  logic [15:0] req_mask = '0;
  logic [16:0] ctrl_word = '0;
  logic [23:0] state_in = '0;
  logic        busy, done;
  logic [63:0] ptr_out;
  logic [23:0] state_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  rnd_tag_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_in(ptr_in),
    .req_mask(req_mask), .ctrl_word(ctrl_word), .state_in(state_in),
    .busy(busy), .done(done), .ptr_out(ptr_out), .state_out(state_out)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  // Reference model written straight from the requirements.
  task automatic model(input logic [63:0] p, input logic [15:0] rm,
                       input logic [16:0] cw, input logic [23:0] si,
                       output logic [63:0] ep, output logic [23:0] es);
    logic [15:0] m;
    logic [15:0] s;
    int off;
    int t;
    m = rm | cw[15:0];
    s = si[23:8];
    if (cw[16] && s == 16'h0) s = 16'h0001;
    off = 0;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = s[0] ^ s[2] ^ s[3] ^ s[5];
      if (b) off = off + (1 << i);
      s = {b, s[15:1]};
    end
    t = si[3:0];
    if (m == 16'hFFFF) begin
      t = 0;
    end else if (off == 0) begin
      for (int k = 0; k < 16 && m[t]; k++) t = (t + 1) % 16;
    end else begin
      for (int j = 0; j < off; j++) begin
        t = (t + 1) % 16;
        for (int k = 0; k < 16 && m[t]; k++) t = (t + 1) % 16;
      end
    end
    ep = p;
    ep[59:56] = t[3:0];
    es = {s, 4'h0, t[3:0]};
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Issue one request and wait for its done pulse; sample away from the edge.
  task automatic run_op(input logic [63:0] p, input logic [15:0] rm,
                        input logic [16:0] cw, input logic [23:0] si);
    int waited;
    @(negedge clk);
    ptr_in = p; req_mask = rm; ctrl_word = cw; state_in = si; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9 no done: actual=0 expected=1");
    end
  endtask

  task automatic op_and_check(input string what, input logic [63:0] p,
                              input logic [15:0] rm, input logic [16:0] cw,
                              input logic [23:0] si);
    logic [63:0] ep;
    logic [23:0] es;
    model(p, rm, cw, si, ep, es);
    run_op(p, rm, cw, si);
    chk({what, " ptr"}, ptr_out, ep);
    chk({what, " state"}, {40'h0, state_out}, {40'h0, es});
  endtask

  task automatic t_reset;
    chk("R10 busy", {63'h0, busy}, 64'h0);
    chk("R10 done", {63'h0, done}, 64'h0);
    chk("R10 ptr_out", ptr_out, 64'h0);
    chk("R10 state_out", {40'h0, state_out}, 64'h0);
  endtask

  task automatic t_basic;
    op_and_check("R2 R5 basic a", 64'h0000_1234_5678_9ABC, 16'h0, 17'h0, 24'hACE1_03);
    op_and_check("R2 R5 basic b", 64'hFF00_0000_0000_0001, 16'h0, 17'h0, 24'h1357_0A);
    op_and_check("R5 masked", 64'h0123_4567_89AB_CDEF, 16'h5555, 17'h0, 24'hBEEF_07);
  endtask

  task automatic t_mask_or;
    op_and_check("R1 req only", 64'h10, 16'h00F0, 17'h0, 24'h4D2A_02);
    op_and_check("R1 ctrl only", 64'h10, 16'h0, 17'h0_0F0F, 24'h4D2A_02);
    op_and_check("R1 both", 64'h10, 16'h3000, 17'h0_00CC, 24'h4D2A_02);
  endtask

  task automatic t_full;
    op_and_check("R3 full via req", 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 17'h0, 24'h9876_0B);
    op_and_check("R3 full via split", 64'h5, 16'hFF00, 17'h0_00FF, 24'h0000_0C);
    chk("R3 tag zero", {60'h0, state_out[3:0]}, 64'h0);
  endtask

  task automatic t_zero_step;
    // Zero seed, random mode off: step count is 0 and the seed stays 0.
    op_and_check("R4 start free", 64'h0, 16'h0, 17'h0, 24'h0000_05);
    chk("R4 start free tag", {60'h0, state_out[3:0]}, 64'h5);
    op_and_check("R4 skip", 64'h0, 16'h0060, 17'h0, 24'h0000_05);
    chk("R4 skip tag", {60'h0, state_out[3:0]}, 64'h7);
    op_and_check("R4 wrap", 64'h0, 16'h8001, 17'h0, 24'h0000_0F);
    chk("R4 wrap tag", {60'h0, state_out[3:0]}, 64'h1);
  endtask

  task automatic t_rnd_seed;
    op_and_check("R6 substitute", 64'h0, 16'h0, 17'h1_0000, 24'h0000_00);
    chk("R6 fixed state", {40'h0, state_out}, 64'h10_0001);
    op_and_check("R6 mode off", 64'h0, 16'h0, 17'h0, 24'h0000_00);
    chk("R6 seed stays", {40'h0, state_out}, 64'h0);
  endtask

  task automatic t_chain;
    logic [23:0] st;
    st = 24'h5A5A_03;
    for (int i = 0; i < 6; i++) begin
      op_and_check("R8 chain", {32'hDEAD_BEEF, 28'h0, 4'(i)}, 16'h0101, 17'h0, st);
      st = state_out;
    end
  endtask

  task automatic t_ptr;
    op_and_check("R7 ones", 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 17'h0, 24'h2468_09);
    chk("R7 low bits", {8'h0, ptr_out[55:0]}, 64'h00FF_FFFF_FFFF_FFFF);
    chk("R7 top bits", {60'h0, ptr_out[63:60]}, 64'hF);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] ep;
    logic [23:0] es;
    int waited;
    int extra;
    model(64'hAAAA, 16'h0, 17'h0, 24'hACE1_00, ep, es);
    @(negedge clk);
    ptr_in = 64'hAAAA; req_mask = 16'h0; ctrl_word = 17'h0; state_in = 24'hACE1_00;
    start = 1'b1;
    @(negedge clk);
    chk("R9 busy after start", {63'h0, busy}, 64'h1);
    ptr_in = 64'h5555; req_mask = 16'hFFFF; state_in = 24'h1111_0F;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 first result ptr", ptr_out, ep);
    chk("R9 first result state", {40'h0, state_out}, {40'h0, es});
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R9 ignored start", 64'(extra), 64'h0);
    chk("R9 outputs held", ptr_out, ep);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] p;
      logic [15:0] rm;
      logic [16:0] cw;
      logic [23:0] si;
      lcg = next_rand(lcg); p[31:0] = lcg;
      lcg = next_rand(lcg); p[63:32] = lcg;
      lcg = next_rand(lcg); rm = lcg[15:0] & lcg[31:16];
      lcg = next_rand(lcg); cw = {lcg[20], lcg[15:0] & lcg[31:16] & 16'h0F0F};
      lcg = next_rand(lcg); si = {lcg[23:8], 4'h0, lcg[3:0]};
      if (i % 7 == 0) si[23:8] = 16'h0;
      op_and_check("R5 sweep", p, rm, cw, si);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask_or();
    t_full();
    t_zero_step();
    t_rnd_seed();
    t_chain();
    t_ptr();
    t_busy_ignore();
    t_sweep();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule